// File: doc/BRIEF.md
# Scale-Space Extremum Keypoint Detector

This block watches three difference-of-Gaussian pixel streams that cover the same image at three neighbouring scales. It finds points where the middle scale holds a strict local peak or a strict local trough in the 3×3×3 cube of samples around it. Pixels of all three scales arrive together, one position per accepted transfer, in raster order. Two row stores per scale provide the two rows above the current one. A two-column window per scale holds the previous columns, so the full cube around the centre is ready as soon as the pixel below and to the right of that centre arrives.

A point that survives the 26-way comparison must also have enough contrast and must not lie on an edge. The edge check uses integer arithmetic on the 2×2 Hessian of the middle scale and needs no division. Each accepted point is packed into a 24-bit word that holds its column, its row, the scale index and a 4-bit magnitude. The word is offered on a valid/ready output port. A single output register provides the storage, and the detector throttles its input while that register is full instead of discarding results.

Top module: `dkd_keypoint_det`

## Requirements
- R1: After reset kp_valid_o is low, and in_ready_o is high while kp_valid_o is low.
- R2: A centre pixel of the middle stream that is strictly greater than all 26 neighbours (its 8 neighbours in the middle scale plus the 9 co-located samples in each other scale) is emitted when it also passes R5 and R6.
- R3: A centre pixel strictly smaller than all 26 neighbours is emitted under the same conditions as R2.
- R4: A centre pixel equal to any one of its 26 neighbours is never emitted.
- R5: A candidate is emitted only when the absolute value of its signed sample is strictly greater than CONTRAST_TH.
- R6: With Dxx = p(x-1,y)+p(x+1,y)-2p, Dyy = p(x,y-1)+p(x,y+1)-2p, K = p(x+1,y+1)-p(x-1,y+1)-p(x+1,y-1)+p(x-1,y-1), T = Dxx+Dyy and D16 = 16·Dxx·Dyy-K², a candidate passes only if D16 > 0 and 16·T²·EDGE_RATIO < (EDGE_RATIO+1)²·D16. Equality rejects.
- R7: No centre in column 0, column IMG_W-1, row 0 or row IMG_H-1 is ever emitted.
- R8: The word is {x[8:0], y[7:0], s[2:0], m[3:0]}, with x at bits 23:15, y at bits 14:7, s at bits 6:4 and m at bits 3:0. x and y are the centre position. s is scale_i sampled on the transfer that completes the window. m is min(|p| >> MAG_SHIFT, 15).
- R9: While kp_valid_o is high and kp_ready_i is low, in_ready_o is low, and on the next cycle kp_valid_o stays high with kp_data_o unchanged. No keypoint is lost.
- R10: The keypoint for centre (x,y) is presented on kp_valid_o in the cycle after the transfer of the pixel at (x+1,y+1).
- R11: Pixel positions are counted from reset in raster order and wrap after IMG_W columns and IMG_H rows, so frames may follow one another with any idle gaps. Keypoints are emitted in raster order of their centres.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A pixel triple is offered |
| in_ready_o | output | 1 | Detector can take the offered triple |
| dog_lo_i | input | DW | Signed sample, finer neighbouring scale |
| dog_mid_i | input | DW | Signed sample, scale under test |
| dog_hi_i | input | DW | Signed sample, coarser neighbouring scale |
| scale_i | input | 3 | Scale index copied into emitted words |
| kp_valid_o | output | 1 | A keypoint word is offered |
| kp_ready_i | input | 1 | Downstream takes the offered word |
| kp_data_o | output | 24 | Packed keypoint word |

## Verification
The assertions assume that exactly IMG_W·IMG_H transfers make up a frame and that the frame fits the 9-bit column and 8-bit row fields. With that, the position counter stays in range, emitted centres never touch the border, and a word can only appear after an input transfer. kp_ready_i may change in any cycle, and the hold property must survive this. The stimulus sends only whole frames of in-range signed samples, holds scale_i constant within a frame, and inserts idle cycles on both the input and output handshakes. It never truncates a frame.

// File: rtl/dkd_pkg.sv
package dkd_pkg;
  localparam int DOG_W = 10;
  localparam int X_W   = 9;
  localparam int Y_W   = 8;
  localparam int S_W   = 3;
  localparam int M_W   = 4;
  localparam int KP_W  = X_W + Y_W + S_W + M_W;

  typedef struct packed {
    logic [X_W-1:0] x;
    logic [Y_W-1:0] y;
    logic [S_W-1:0] scale;
    logic [M_W-1:0] mag;
  } kp_word_t;
endpackage

// File: rtl/dkd_line_buf.sv
module dkd_line_buf #(
  parameter int IMG_W = 64,
  parameter int DW    = 10,
  localparam int CW   = $clog2(IMG_W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 adv_i,
  input  logic [CW-1:0]        col_i,
  input  logic signed [DW-1:0] pix_i,
  output logic signed [DW-1:0] up1_o,
  output logic signed [DW-1:0] up2_o
);
  // two stacked rows, addressed by column: row1 = previous row, row2 = the one before
  logic signed [DW-1:0] row1_q [IMG_W];
  logic signed [DW-1:0] row2_q [IMG_W];

  assign up1_o = row1_q[col_i];
  assign up2_o = row2_q[col_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < IMG_W; i++) begin
        row1_q[i] <= '0;
        row2_q[i] <= '0;
      end
    end else if (adv_i) begin
      row1_q[col_i] <= pix_i;
      row2_q[col_i] <= row1_q[col_i];
    end
  end

  // R11
  col_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> (int'(col_i) < IMG_W));
endmodule

// File: rtl/dkd_extremum.sv
module dkd_extremum #(
  parameter int DW = 10,
  localparam int NC  = 27,
  localparam int CTR = 13
) (
  input  logic signed [DW-1:0] cube_i [NC],
  output logic                 is_max_o,
  output logic                 is_min_o
);
  logic [NC-1:0] gt, lt;

  for (genvar i = 0; i < NC; i++) begin : g_cmp
    if (i == CTR) begin : g_self
      assign gt[i] = 1'b1;
      assign lt[i] = 1'b1;
    end else begin : g_nb
      assign gt[i] = cube_i[CTR] > cube_i[i];
      assign lt[i] = cube_i[CTR] < cube_i[i];
    end
  end

  // strict on every side: any tie clears both
  assign is_max_o = &gt;
  assign is_min_o = &lt;
endmodule

// File: rtl/dkd_edge_test.sv
module dkd_edge_test #(
  parameter int DW    = 10,
  parameter int RATIO = 10,
  localparam int WW   = 4*DW + 16
) (
  input  logic signed [DW-1:0] m_i [9],
  output logic                 pass_o
);
  localparam logic signed [WW-1:0] RK  = WW'(RATIO);
  localparam logic signed [WW-1:0] R1Q = WW'((RATIO+1)*(RATIO+1));

  logic signed [WW-1:0] e [9];
  logic signed [WW-1:0] dxx, dyy, k4, tr4, det16, lhs, rhs;

  for (genvar i = 0; i < 9; i++) begin : g_ext
    assign e[i] = WW'(m_i[i]);
  end

  // cross term kept at 4x scale; trace and det scaled to match (x4, x16)
  assign dxx   = e[3] + e[5] - (e[4] <<< 1);
  assign dyy   = e[1] + e[7] - (e[4] <<< 1);
  assign k4    = e[8] - e[6] - e[2] + e[0];
  assign tr4   = (dxx + dyy) <<< 2;
  assign det16 = ((dxx * dyy) <<< 4) - k4 * k4;
  assign lhs   = tr4 * tr4 * RK;
  assign rhs   = det16 * R1Q;

  assign pass_o = (det16 > 0) && (lhs < rhs);
endmodule

// File: rtl/dkd_keypoint_det.sv
module dkd_keypoint_det import dkd_pkg::*; #(
  parameter int IMG_W       = 64,
  parameter int IMG_H       = 32,
  parameter int DW          = DOG_W,
  parameter int CONTRAST_TH = 8,
  parameter int MAG_SHIFT   = 5,
  parameter int EDGE_RATIO  = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic signed [DW-1:0] dog_lo_i,
  input  logic signed [DW-1:0] dog_mid_i,
  input  logic signed [DW-1:0] dog_hi_i,
  input  logic [S_W-1:0]       scale_i,
  output logic                 kp_valid_o,
  input  logic                 kp_ready_i,
  output logic [KP_W-1:0]      kp_data_o
);
  localparam int CW  = $clog2(IMG_W);
  localparam int RW  = $clog2(IMG_H);
  localparam int NS  = 3;
  localparam int NC  = 27;
  localparam int CTR = 13;
  localparam int MSAT = (1 << M_W) - 1;

  logic            adv, hit;
  logic [CW-1:0]   col_q;
  logic [RW-1:0]   row_q;
  logic signed [DW-1:0] pix_in [NS];
  logic signed [DW-1:0] up1 [NS];
  logic signed [DW-1:0] up2 [NS];
  logic signed [DW-1:0] win_q [NS][3][2];
  logic signed [DW-1:0] cube [NC];
  logic signed [DW-1:0] mid [9];
  logic signed [DW-1:0] centre;
  logic [DW-1:0]   mag_abs, mag_sh;
  logic            is_max, is_min, edge_ok, contrast_ok, in_region;
  kp_word_t        kp_q, kp_next;
  logic            kp_valid_q;

  assign in_ready_o = !kp_valid_q || kp_ready_i;
  assign adv        = in_valid_i && in_ready_o;

  assign pix_in[0] = dog_lo_i;
  assign pix_in[1] = dog_mid_i;
  assign pix_in[2] = dog_hi_i;

  // raster position of the incoming triple
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (adv) begin
      if (col_q == CW'(IMG_W-1)) begin
        col_q <= '0;
        row_q <= (row_q == RW'(IMG_H-1)) ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_scale
    dkd_line_buf #(.IMG_W(IMG_W), .DW(DW)) u_lb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .adv_i (adv),
      .col_i (col_q),
      .pix_i (pix_in[s]),
      .up1_o (up1[s]),
      .up2_o (up2[s])
    );
    for (genvar r = 0; r < 3; r++) begin : g_row
      assign cube[s*9 + r*3 + 0] = win_q[s][r][0];
      assign cube[s*9 + r*3 + 1] = win_q[s][r][1];
      if (r == 0) begin : g_r0
        assign cube[s*9 + 2] = up2[s];
      end else if (r == 1) begin : g_r1
        assign cube[s*9 + 5] = up1[s];
      end else begin : g_r2
        assign cube[s*9 + 8] = pix_in[s];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NS; s++)
        for (int r = 0; r < 3; r++)
          for (int k = 0; k < 2; k++)
            win_q[s][r][k] <= '0;
    end else if (adv) begin
      for (int s = 0; s < NS; s++)
        for (int r = 0; r < 3; r++) begin
          win_q[s][r][0] <= win_q[s][r][1];
          win_q[s][r][1] <= cube[s*9 + r*3 + 2];
        end
    end
  end

  for (genvar i = 0; i < 9; i++) begin : g_mid
    assign mid[i] = cube[9 + i];
  end

  dkd_extremum #(.DW(DW)) u_ext (
    .cube_i  (cube),
    .is_max_o(is_max),
    .is_min_o(is_min)
  );

  dkd_edge_test #(.DW(DW), .RATIO(EDGE_RATIO)) u_edge (
    .m_i   (mid),
    .pass_o(edge_ok)
  );

  assign centre      = cube[CTR];
  assign mag_abs     = centre[DW-1] ? (~centre + 1'b1) : centre;
  assign mag_sh      = mag_abs >> MAG_SHIFT;
  assign contrast_ok = mag_abs > DW'(CONTRAST_TH);
  // centre sits one column left, one row up of the incoming pixel
  assign in_region   = (col_q >= CW'(2)) && (row_q >= RW'(2));
  assign hit         = in_region && (is_max || is_min) && contrast_ok && edge_ok;

  always_comb begin
    kp_next.x     = X_W'(col_q) - X_W'(1);
    kp_next.y     = Y_W'(row_q) - Y_W'(1);
    kp_next.scale = scale_i;
    kp_next.mag   = (mag_sh > DW'(MSAT)) ? M_W'(MSAT) : mag_sh[M_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kp_valid_q <= 1'b0;
      kp_q       <= '0;
    end else if (adv && hit) begin
      kp_valid_q <= 1'b1;
      kp_q       <= kp_next;
    end else if (kp_ready_i) begin
      kp_valid_q <= 1'b0;
    end
  end

  assign kp_valid_o = kp_valid_q;
  assign kp_data_o  = kp_q;

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kp_valid_o && !kp_ready_i |=> kp_valid_o && $stable(kp_data_o));

  // R10
  new_kp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(kp_valid_o) |-> $past(in_valid_i && in_ready_o));

  // R7
  border_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kp_valid_o |-> (kp_q.x >= X_W'(1)) && (kp_q.x <= X_W'(IMG_W-2)) &&
                   (kp_q.y >= Y_W'(1)) && (kp_q.y <= Y_W'(IMG_H-2)));
endmodule

// File: tb/dkd_keypoint_det_test.sv
`timescale 1ns/1ps
module dkd_keypoint_det_test;
  localparam int W = 12;
  localparam int H = 8;
  localparam int N = W*H;
  localparam int TH = 8;
  localparam int MSH = 5;
  localparam int RAT = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic in_ready_o;
  logic signed [9:0] dog_lo_i = '0, dog_mid_i = '0, dog_hi_i = '0;
  logic [2:0] scale_i = '0;
  logic kp_valid_o;
  logic kp_ready_i = 1'b0;
  logic [23:0] kp_data_o;

  always #2 clk = ~clk;

  dkd_keypoint_det #(.IMG_W(W), .IMG_H(H), .DW(10), .CONTRAST_TH(TH),
                     .MAG_SHIFT(MSH), .EDGE_RATIO(RAT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .dog_lo_i(dog_lo_i), .dog_mid_i(dog_mid_i), .dog_hi_i(dog_hi_i),
    .scale_i(scale_i), .kp_valid_o(kp_valid_o), .kp_ready_i(kp_ready_i),
    .kp_data_o(kp_data_o));

  int fr [3][H][W];
  int exp_w [N];
  int exp_n;
  int acc_cyc [N];
  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic int kp_word(input int x, input int y, input int sc);
    int c, a, m, dxx, dyy, k4, t;
    longint d16, l, r;
    bit mx, mn;
    c = fr[1][y][x];
    mx = 1; mn = 1;
    for (int s = 0; s < 3; s++)
      for (int dy = -1; dy <= 1; dy++)
        for (int dx = -1; dx <= 1; dx++)
          if (!(s == 1 && dy == 0 && dx == 0)) begin
            if (!(c > fr[s][y+dy][x+dx])) mx = 0;
            if (!(c < fr[s][y+dy][x+dx])) mn = 0;
          end
    if (!(mx || mn)) return -1;
    a = (c < 0) ? -c : c;
    if (!(a > TH)) return -1;
    dxx = fr[1][y][x-1] + fr[1][y][x+1] - 2*c;
    dyy = fr[1][y-1][x] + fr[1][y+1][x] - 2*c;
    k4  = fr[1][y+1][x+1] - fr[1][y+1][x-1] - fr[1][y-1][x+1] + fr[1][y-1][x-1];
    t = dxx + dyy;
    d16 = 16*longint'(dxx)*longint'(dyy) - longint'(k4)*longint'(k4);
    l = 16*longint'(t)*longint'(t)*RAT;
    r = longint'((RAT+1)*(RAT+1))*d16;
    if (!(d16 > 0 && l < r)) return -1;
    m = a >> MSH;
    if (m > 15) m = 15;
    return (x << 15) | (y << 7) | ((sc & 7) << 4) | m;
  endfunction

  task automatic clear_frame();
    for (int s = 0; s < 3; s++)
      for (int y = 0; y < H; y++)
        for (int x = 0; x < W; x++)
          fr[s][y][x] = 0;
  endtask

  task automatic rand_frame(input int amp);
    for (int s = 0; s < 3; s++)
      for (int y = 0; y < H; y++)
        for (int x = 0; x < W; x++)
          fr[s][y][x] = (amp >= 512) ? int'($urandom_range(0, 1023)) - 512
                                     : int'($urandom_range(0, 2*amp)) - amp;
  endtask

  task automatic run_frame(input string tag, input int bp, input int vp, input int sc);
    int pix, drain, oi, w;
    bit kv, pkv, pkr, pir, ir;
    logic [23:0] kd, pkd;
    exp_n = 0;
    for (int y = 1; y < H-1; y++)
      for (int x = 1; x < W-1; x++) begin
        w = kp_word(x, y, sc);
        if (w >= 0) begin exp_w[exp_n] = w; exp_n++; end
      end
    pix = 0; drain = 0; oi = 0;
    pkv = 0; pkr = 0; pir = 1; pkd = '0;
    while (pix < N || drain < 12) begin
      @(negedge clk);
      kp_ready_i = ($urandom_range(0, 99) < bp);
      scale_i = 3'(sc);
      if (pix < N && $urandom_range(0, 99) < vp) begin
        in_valid_i = 1'b1;
        dog_lo_i  = 10'(fr[0][pix / W][pix % W]);
        dog_mid_i = 10'(fr[1][pix / W][pix % W]);
        dog_hi_i  = 10'(fr[2][pix / W][pix % W]);
      end else begin
        in_valid_i = 1'b0;
      end
      #1;
      kv = kp_valid_o; kd = kp_data_o; ir = in_ready_o;
      if (pkv && !pkr) begin
        // R9 word held while stalled, and input blocked in that cycle
        check(kv == 1'b1 && kd == pkd, "R9 hold", int'(kd), int'(pkd));
        check(pir == 1'b0, "R9 ready low", int'(pir), 0);
      end else if (kv) begin
        int x, y, idx;
        x = int'(kd[23:15]); y = int'(kd[14:7]);
        if (oi < exp_n) check(int'(kd) == exp_w[oi], tag, int'(kd), exp_w[oi]);
        else check(0, {tag, " extra word"}, int'(kd), 0);
        oi++;
        idx = (y+1)*W + (x+1);
        if (idx >= 0 && idx < N && idx < pix)
          check(cyc == acc_cyc[idx] + 1, "R10 latency", cyc, acc_cyc[idx] + 1);
        else check(0, "R10 R7 position", idx, 0);
      end
      if (in_valid_i && ir) begin
        acc_cyc[pix] = cyc;
        pix++;
      end
      if (pix >= N) drain++;
      pkv = kv; pkr = kp_ready_i; pkd = kd; pir = ir;
      cyc++;
    end
    in_valid_i = 1'b0;
    check(oi == exp_n, {tag, " R11 count"}, oi, exp_n);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    // R1
    check(kp_valid_o == 1'b0, "R1 valid", int'(kp_valid_o), 0);
    check(in_ready_o == 1'b1, "R1 ready", int'(in_ready_o), 1);

    clear_frame();
    fr[1][3][3] = 100; fr[1][4][8] = 511;
    run_frame("R2 R8 max", 100, 100, 5);
    check(exp_n == 2, "R2 model count", exp_n, 2);

    clear_frame();
    fr[1][2][4] = -200; fr[1][5][8] = -512;
    run_frame("R3 R8 min", 60, 90, 2);
    check(exp_n == 2, "R3 model count", exp_n, 2);

    clear_frame();
    fr[1][3][3] = 50; fr[1][3][4] = 50;
    fr[1][4][8] = 60; fr[2][4][8] = 60;
    fr[1][5][5] = 70; fr[0][6][6] = 70;
    run_frame("R4 tie", 70, 90, 1);
    check(exp_n == 0, "R4 model count", exp_n, 0);

    clear_frame();
    fr[1][3][3] = 8; fr[1][3][8] = 9; fr[1][5][5] = -8; fr[1][6][9] = -9;
    run_frame("R5 contrast", 80, 100, 3);
    check(exp_n == 2, "R5 model count", exp_n, 2);

    clear_frame();
    fr[1][3][3] = 100; fr[1][3][2] = 90; fr[1][3][4] = 90;
    fr[1][4][8] = 100; fr[1][4][7] = 80; fr[1][4][9] = 80;
    run_frame("R6 edge", 50, 100, 6);
    check(exp_n == 1, "R6 model count", exp_n, 1);

    clear_frame();
    fr[1][3][0] = 100; fr[1][3][11] = 100; fr[1][0][5] = 100;
    fr[1][7][5] = 100; fr[1][0][0] = -100;
    run_frame("R7 border", 100, 100, 4);
    check(exp_n == 0, "R7 model count", exp_n, 0);

    for (int f = 0; f < 20; f++) begin
      rand_frame((f % 2 == 0) ? 40 : 512);
      run_frame("R11 R2 R3 random", (f == 5) ? 10 : int'($urandom_range(40, 100)),
                int'($urandom_range(60, 100)), int'($urandom_range(0, 7)));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule